// File: doc/BRIEF.md
# Packet Lane Serializer and Deserializer

This block moves fixed-length packets across a narrow lane of a packet-oriented memory bus. A packet is cut into eight slices. Each slice occupies one transfer slot on the lane. The real bus moves two slices per bus clock, one on each edge. Here that rate is modelled with a single clock running at twice the bus rate, so each rising edge of `clk` is one transfer slot and eight slots make one four-bus-cycle packet.

The transmit half takes a parallel payload and a one-cycle start pulse. It then drives the lane for eight consecutive slots, most significant slice first, with a valid strobe. The receive half counts valid slots on its own lane input and shifts each slice in at the least significant end. After the eighth slice it presents the rebuilt payload together with a one-cycle done pulse.

The single parameter `LANE_W` selects the lane:

| `LANE_W` | Lane kind | Payload bits |
|---|---|---|
| 3 | row-address lane | 12 |
| 5 | column-address lane | 20 |
| 16 | data lane | 128 |
| 18 | data lane with check bits | 144 |

The transmit and receive halves have separate lane ports. A system wires one end's transmit lane to the far end's receive lane.

Top module: `packet_lane_serdes`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `tx_vld` is 0, `tx_lane` is 0, `rx_done` is 0 and `rx_payload` is 0.
- R2: The payload width is derived from `LANE_W`. Lanes narrower than 8 bits carry SLOTS*LANE_W/2 payload bits (3 gives 12, 5 gives 20). Wider lanes carry SLOTS*LANE_W bits (16 gives 128, 18 gives 144). A packet is always SLOTS = 8 slices.
- R3: A `tx_start` pulse seen while the transmitter is idle makes `tx_vld` rise in the next cycle. `tx_vld` then stays high for exactly 8 consecutive cycles.
- R4: The transmitted frame is the payload zero-extended to 8*LANE_W bits. Slot k (k = 0 first) carries frame bits [8*LANE_W-1-k*LANE_W -: LANE_W], so the most significant slice goes first.
- R5: When the payload is narrower than the frame, the leading slices, which hold no payload bits, are driven as all zeros.
- R6: A `tx_start` seen during slots 0 to 6 of a packet in flight is ignored. The packet in flight continues unchanged, and no further packet follows it.
- R7: A `tx_start` seen during slot 7 is accepted. The new packet's slot 0 follows in the next cycle, with no idle slot between the two packets.
- R8: The receiver takes a slice only in cycles where `rx_vld` is 1, so idle cycles between slices are allowed. In the cycle after the eighth taken slice, `rx_done` is 1 and `rx_payload` equals the low payload bits of the eight slices, the first slice taken being the most significant.
- R9: `rx_done` is high for one cycle per packet. `rx_payload` holds its value between `rx_done` pulses.
- R10: Receiver frame bits above the payload width are discarded. Nonzero values in the leading slices do not change `rx_payload`.
- R11: `tx_lane` is all zeros in every cycle where `tx_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer-slot clock, one edge per lane transfer |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | One-cycle request to send `tx_payload` |
| tx_payload | input | PAY_W | Parallel payload to send |
| tx_lane | output | LANE_W | Transmit lane slice |
| tx_vld | output | 1 | High while a slice is on `tx_lane` |
| rx_lane | input | LANE_W | Receive lane slice |
| rx_vld | input | 1 | High when `rx_lane` carries a slice |
| rx_payload | output | PAY_W | Rebuilt payload |
| rx_done | output | 1 | One-cycle pulse when `rx_payload` is updated |

## Verification
The bench loops the transmit lane back to the receive lane and sends several payloads:
- A mixed value shows that slices go out in the right order.
- All ones and a single top bit show that the zero-extended slices stay zero, and that the top payload bit lands in the right slice.
- A single low bit shows that the last slice is handled correctly.

A second start placed in slot 3 separates an ignored request from an accepted one, and a start placed in slot 7 shows gapless chaining. The receiver is also driven directly with idle gaps and nonzero leading slices. These cases separate counting of valid slots from counting of clock cycles, and show whether the leading bits are discarded.

// File: rtl/packet_lane_pkg.sv
package packet_lane_pkg;

  // Payload bits carried by a packet of `slots` slices on a lane `lane_w` wide.
  // Narrow address lanes fill only half of the frame.
  function automatic int unsigned payload_bits(int unsigned lane_w, int unsigned slots);
    if (lane_w < 8) begin
      return (lane_w * slots) / 2;
    end
    return lane_w * slots;
  endfunction

endpackage

// File: rtl/lane_rst_sync.sv
module lane_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;

endmodule

// File: rtl/lane_slot_ctr.sv
module lane_slot_ctr #(
  parameter int unsigned SLOTS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     en,
  output logic [$clog2(SLOTS)-1:0] idx,
  output logic                     last
);

  localparam int unsigned CNT_W = $clog2(SLOTS);

  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] idx_d;

  assign last = (idx_q == CNT_W'(SLOTS - 1));
  assign idx  = idx_q;

  always_comb begin
    idx_d = idx_q;
    if (clr) begin
      idx_d = '0;
    end else if (en) begin
      idx_d = last ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (clr || en) begin
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/lane_tx.sv
module lane_tx
  import packet_lane_pkg::*;
#(
  parameter int unsigned LANE_W = 5,
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned PAY_W  = payload_bits(LANE_W, SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAY_W-1:0]  payload,
  output logic [LANE_W-1:0] lane,
  output logic              vld
);

  localparam int unsigned FRAME_W = SLOTS * LANE_W;
  localparam int unsigned CNT_W   = $clog2(SLOTS);

  logic               active_q;
  logic               active_d;
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_d;
  logic [FRAME_W-1:0] frame_wide;
  logic [CNT_W-1:0]   slot_idx;
  logic               slot_last;
  logic               accept;

  generate
    if (PAY_W < FRAME_W) begin : g_pad
      assign frame_wide = {{(FRAME_W - PAY_W){1'b0}}, payload};
    end else begin : g_full
      assign frame_wide = payload;
    end
  endgenerate

  // A start is taken when idle, or in the last slot so that packets chain.
  assign accept = start && (!active_q || slot_last);

  lane_slot_ctr #(.SLOTS(SLOTS)) u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (active_q),
    .idx   (slot_idx),
    .last  (slot_last)
  );

  always_comb begin
    active_d = active_q;
    frame_d  = frame_q;
    if (accept) begin
      active_d = 1'b1;
      frame_d  = frame_wide;
    end else if (active_q) begin
      active_d = !slot_last;
      frame_d  = frame_q << LANE_W;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      frame_q  <= '0;
    end else if (accept || active_q) begin
      active_q <= active_d;
      frame_q  <= frame_d;
    end
  end

  assign lane = frame_q[FRAME_W-1 -: LANE_W];
  assign vld  = active_q;

endmodule

// File: rtl/lane_rx.sv
module lane_rx
  import packet_lane_pkg::*;
#(
  parameter int unsigned LANE_W = 5,
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned PAY_W  = payload_bits(LANE_W, SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] lane,
  input  logic              vld,
  output logic [PAY_W-1:0]  payload,
  output logic              done
);

  localparam int unsigned FRAME_W = SLOTS * LANE_W;
  localparam int unsigned CNT_W   = $clog2(SLOTS);

  logic [FRAME_W-1:0] asm_q;
  logic [FRAME_W-1:0] asm_d;
  logic [PAY_W-1:0]   pay_q;
  logic [PAY_W-1:0]   pay_d;
  logic               done_q;
  logic               done_d;
  logic [CNT_W-1:0]   slot_idx;
  logic               slot_last;
  logic               complete;

  lane_slot_ctr #(.SLOTS(SLOTS)) u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (1'b0),
    .en    (vld),
    .idx   (slot_idx),
    .last  (slot_last)
  );

  assign complete = vld && slot_last;

  always_comb begin
    asm_d  = asm_q;
    pay_d  = pay_q;
    done_d = complete;
    if (vld) begin
      asm_d = {asm_q[FRAME_W-LANE_W-1:0], lane};
    end
    if (complete) begin
      pay_d = asm_d[PAY_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q <= '0;
    end else if (vld) begin
      asm_q <= asm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_q <= '0;
    end else if (complete) begin
      pay_q <= pay_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign payload = pay_q;
  assign done    = done_q;

endmodule

// File: rtl/packet_lane_serdes.sv
module packet_lane_serdes
  import packet_lane_pkg::*;
#(
  parameter int unsigned LANE_W = 5,
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned PAY_W  = payload_bits(LANE_W, SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic [PAY_W-1:0]  tx_payload,
  output logic [LANE_W-1:0] tx_lane,
  output logic              tx_vld,
  input  logic [LANE_W-1:0] rx_lane,
  input  logic              rx_vld,
  output logic [PAY_W-1:0]  rx_payload,
  output logic              rx_done
);

  logic rst_n_sync;

  lane_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lane_tx #(.LANE_W(LANE_W), .SLOTS(SLOTS), .PAY_W(PAY_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .start   (tx_start),
    .payload (tx_payload),
    .lane    (tx_lane),
    .vld     (tx_vld)
  );

  lane_rx #(.LANE_W(LANE_W), .SLOTS(SLOTS), .PAY_W(PAY_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .lane    (rx_lane),
    .vld     (rx_vld),
    .payload (rx_payload),
    .done    (rx_done)
  );

endmodule

// File: rtl/packet_lane_serdes_chk.sv
module packet_lane_serdes_chk #(
  parameter int unsigned LANE_W = 5,
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned PAY_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LANE_W-1:0] tx_lane,
  input logic              tx_vld,
  input logic              rx_vld,
  input logic [PAY_W-1:0]  rx_payload,
  input logic              rx_done
);

  localparam int unsigned FRAME_W = SLOTS * LANE_W;
  localparam int unsigned CNT_W   = $clog2(SLOTS);
  localparam int unsigned ZS      = (FRAME_W - PAY_W) / LANE_W;

  logic [CNT_W-1:0] tx_run_q;
  logic [CNT_W-1:0] rx_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_run_q <= '0;
      rx_run_q <= '0;
    end else begin
      if (tx_vld) begin
        tx_run_q <= (tx_run_q == CNT_W'(SLOTS - 1)) ? '0 : tx_run_q + 1'b1;
      end
      if (rx_vld) begin
        rx_run_q <= (rx_run_q == CNT_W'(SLOTS - 1)) ? '0 : rx_run_q + 1'b1;
      end
    end
  end

  // R3
  tx_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_vld) |-> (tx_run_q == '0));

  // R3
  tx_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && (tx_run_q != CNT_W'(SLOTS - 1))) |=> tx_vld);

  // R11
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_vld |-> (tx_lane == '0));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> ($past(rx_vld) && (rx_run_q == '0)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R9
  payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> $stable(rx_payload));

  generate
    if (ZS > 0) begin : g_zero_fill
      // R5
      lead_slice_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_vld && (tx_run_q < CNT_W'(ZS))) |-> (tx_lane == '0));
    end
  endgenerate

endmodule

bind packet_lane_serdes packet_lane_serdes_chk #(
  .LANE_W (LANE_W),
  .SLOTS  (SLOTS),
  .PAY_W  (PAY_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .tx_lane    (tx_lane),
  .tx_vld     (tx_vld),
  .rx_vld     (rx_vld),
  .rx_payload (rx_payload),
  .rx_done    (rx_done)
);

// File: tb/packet_lane_serdes_bench.sv
module packet_lane_serdes_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LANE_W     = 5;
  localparam int PAY_W      = 20;
  localparam int FRAME_W    = 40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tx_start = 1'b0;
  logic [PAY_W-1:0]  tx_payload = '0;
  logic [LANE_W-1:0] tx_lane;
  logic              tx_vld;
  logic [LANE_W-1:0] rx_lane;
  logic              rx_vld;
  logic [PAY_W-1:0]  rx_payload;
  logic              rx_done;

  logic              loop_en = 1'b1;
  logic [LANE_W-1:0] drv_lane = '0;
  logic              drv_vld = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  assign rx_lane = loop_en ? tx_lane : drv_lane;
  assign rx_vld  = loop_en ? tx_vld  : drv_vld;

  always #(CLK_PERIOD / 2) clk = ~clk;

  packet_lane_serdes u_packet_lane_serdes (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_start   (tx_start),
    .tx_payload (tx_payload),
    .tx_lane    (tx_lane),
    .tx_vld     (tx_vld),
    .rx_lane    (rx_lane),
    .rx_vld     (rx_vld),
    .rx_payload (rx_payload),
    .rx_done    (rx_done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [LANE_W-1:0] slice_of(input logic [PAY_W-1:0] p, input int k);
    logic [FRAME_W-1:0] f;
    f = {{(FRAME_W - PAY_W){1'b0}}, p};
    return f[FRAME_W-1-k*LANE_W -: LANE_W];
  endfunction

  // Check the eight slots of packet p, one per negedge, starting in slot 0.
  task automatic watch_slots(input logic [PAY_W-1:0] p, input string tag);
    for (int k = 0; k < 8; k++) begin
      check(tx_vld === 1'b1, {tag, " R3 vld"}, 64'(tx_vld), 64'd1);
      check(tx_lane === slice_of(p, k), {tag, " R4 slice"}, 64'(tx_lane), 64'(slice_of(p, k)));
      if (k < 4) check(tx_lane === '0, {tag, " R5 lead zero"}, 64'(tx_lane), 64'd0);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_vld === 1'b0 && rx_done === 1'b0, "R1 ctl in reset", 64'({tx_vld, rx_done}), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_vld === 1'b0, "R1 tx_vld", 64'(tx_vld), 64'd0);
    check(tx_lane === '0, "R1 R11 tx_lane", 64'(tx_lane), 64'd0);
    check(rx_done === 1'b0, "R1 rx_done", 64'(rx_done), 64'd0);
    check(rx_payload === '0, "R1 rx_payload", 64'(rx_payload), 64'd0);
  endtask

  task automatic send_one(input logic [PAY_W-1:0] p);
    tx_start = 1'b1;
    tx_payload = p;
    @(negedge clk);
    tx_start = 1'b0;
    watch_slots(p, "single");
    check(tx_vld === 1'b0, "R3 vld low after 8", 64'(tx_vld), 64'd0);
    check(tx_lane === '0, "R11 idle lane", 64'(tx_lane), 64'd0);
    check(rx_done === 1'b1, "R8 done", 64'(rx_done), 64'd1);
    check(rx_payload === p, "R8 R2 payload", 64'(rx_payload), 64'(p));
    @(negedge clk);
    check(rx_done === 1'b0, "R9 done one cycle", 64'(rx_done), 64'd0);
    check(rx_payload === p, "R9 payload held", 64'(rx_payload), 64'(p));
  endtask

  task automatic busy_ignore(input logic [PAY_W-1:0] a, input logic [PAY_W-1:0] b);
    tx_start = 1'b1;
    tx_payload = a;
    @(negedge clk);
    tx_start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check(tx_lane === slice_of(a, k), "R6 slice kept", 64'(tx_lane), 64'(slice_of(a, k)));
      if (k == 3) begin
        tx_start = 1'b1;
        tx_payload = b;
      end else begin
        tx_start = 1'b0;
      end
      @(negedge clk);
    end
    check(rx_payload === a, "R6 old packet", 64'(rx_payload), 64'(a));
    for (int k = 0; k < 9; k++) begin
      check(tx_vld === 1'b0, "R6 no extra packet", 64'(tx_vld), 64'd0);
      @(negedge clk);
    end
  endtask

  task automatic chain(input logic [PAY_W-1:0] a, input logic [PAY_W-1:0] b);
    tx_start = 1'b1;
    tx_payload = a;
    @(negedge clk);
    tx_start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check(tx_lane === slice_of(a, k), "R7 first slice", 64'(tx_lane), 64'(slice_of(a, k)));
      if (k == 7) begin
        tx_start = 1'b1;
        tx_payload = b;
      end
      @(negedge clk);
    end
    tx_start = 1'b0;
    check(rx_done === 1'b1 && rx_payload === a, "R7 first done", 64'(rx_payload), 64'(a));
    watch_slots(b, "chain R7");
    check(rx_done === 1'b1 && rx_payload === b, "R7 second done", 64'(rx_payload), 64'(b));
    @(negedge clk);
  endtask

  // Direct receive drive with idle gaps and junk in the leading slices.
  task automatic rx_gaps();
    logic [FRAME_W-1:0] f;
    logic [PAY_W-1:0]   exp;
    f = 40'hF7_BDEF_1234 ^ 40'h00_0000_5A5A;
    exp = f[PAY_W-1:0];
    loop_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      drv_lane = f[FRAME_W-1-k*LANE_W -: LANE_W];
      drv_vld = 1'b1;
      @(negedge clk);
      if (k == 7) begin
        check(rx_done === 1'b1, "R8 done after 8 valid", 64'(rx_done), 64'd1);
        check(rx_payload === exp, "R10 R8 low bits", 64'(rx_payload), 64'(exp));
      end else begin
        check(rx_done === 1'b0, "R8 no early done", 64'(rx_done), 64'd0);
      end
      drv_vld = 1'b0;
      drv_lane = 5'h1F;
      @(negedge clk);
      check(rx_done === 1'b0, "R8 R9 idle gap", 64'(rx_done), 64'd0);
    end
    loop_en = 1'b1;
    drv_lane = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    send_one(20'hA5C3E);
    send_one(20'hFFFFF);
    send_one(20'h80000);
    send_one(20'h00001);
    busy_ignore(20'h12345, 20'hFEDCB);
    chain(20'h5AA5F, 20'hC0FFE);
    rx_gaps();
    send_one(20'h3C3C3);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule